// File: doc/BRIEF.md
# Prioritized Address Mode Decoder

This block sits in front of the address translation unit and classifies every bus access as physical or virtual. It compares the access address with a bank of mapping windows. The bank holds one window for the MMU control registers, two on-chip RAM windows, two on-chip ROM windows and two access-control windows. A window that hits makes the access physical. The access is then not translated, and its attributes come from the winning window. An access that hits no window goes to the translation unit as virtual, unless the translation unit is absent or turned off.

Each window holds a valid bit, a base, a mask, an instruction enable, a data enable and an attribute byte. Software loads each window as one whole write through a small configuration port. The same port also sets a default attribute value. That default applies only where no translation takes place: special-mode accesses, and accesses that miss every window while the MMU is off. The decision is registered, so the result appears one cycle after the request.

Top module: `addr_mode_decoder`

## Requirements
- R1: After reset, valid_o=0, virt_o=0, src_o=7 and attr_o=0. Every window is invalid and the default attribute is 0.
- R2: A special-mode access (special_i=1) is physical, with src_o=7 and attr_o equal to the default attribute, even when a window matches.
- R3: If mmu_present_i=0 or mmu_enable_i=0, an access that hits no window is physical, with src_o=7 and attr_o equal to the default attribute.
- R4: Source indices are 0 for the MMU window, 1–2 for RAM0–RAM1, 3–4 for ROM0–ROM1 and 5–6 for ACR0–ACR1. When several windows hit, the lowest index wins, so the MMU window beats RAM, RAM beats ROM, ROM beats ACR, and within a group the lower number wins.
- R5: Window 0 (MMU control) can hit only for a data access (is_data_i=1) in supervisor mode (super_i=1) with mmu_present_i=1.
- R6: An access that hits a window is physical (virt_o=0), with src_o set to the winning index and attr_o set to that window's attribute.
- R7: With the MMU present and enabled, a non-special access that hits no window is virtual: virt_o=1, src_o=7 and attr_o=0. The default attribute is not applied.
- R8: A window hits only if three conditions all hold: it is valid, ((addr_i ^ base) & mask) == 0, and its enable for the access kind is set (en_inst for is_data_i=0, en_data for is_data_i=1).
- R9: Outputs are registered. The result for a request held on the inputs at one rising edge appears after that edge, and valid_o is req_valid_i delayed by one cycle.
- R10: A configuration write (cfg_we_i=1) with cfg_idx_i from 0 to 6 loads that whole window. cfg_idx_i=7 loads the default attribute from cfg_attr_i. A write affects requests presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 3 | Window index 0–6, or 7 for the default attribute |
| cfg_valid_i | input | 1 | Window valid bit |
| cfg_en_inst_i | input | 1 | Window matches instruction accesses |
| cfg_en_data_i | input | 1 | Window matches data accesses |
| cfg_base_i | input | 32 | Window base address |
| cfg_mask_i | input | 32 | Window compare mask |
| cfg_attr_i | input | 8 | Window attribute or default attribute |
| mmu_present_i | input | 1 | Translation unit is present |
| mmu_enable_i | input | 1 | Translation unit is enabled |
| req_valid_i | input | 1 | Access request valid |
| addr_i | input | 32 | Access address |
| is_data_i | input | 1 | 1 = data access, 0 = instruction fetch |
| super_i | input | 1 | Supervisor mode |
| special_i | input | 1 | Special-mode access (interrupt acknowledge, debug) |
| valid_o | output | 1 | Result valid |
| virt_o | output | 1 | 0 = physical, 1 = virtual |
| src_o | output | 3 | Winning window index, 7 when none |
| attr_o | output | 8 | Selected attributes |

## Verification
The bench stacks overlapping windows so that the priority chain is exercised across groups and within a group. A decoder with the order reversed, or one that takes the highest index, would report the wrong source. The MMU control window is tried with a user-mode data access and with an instruction fetch. An implementation that ignored the kind or privilege qualifier would claim those accesses instead of letting them fall through to RAM. Three cases tell the default attribute apart: a miss with the MMU on must show attribute zero and virtual, while a special-mode access and a miss with the MMU off must both show the default. This catches a decoder that leaks the default into virtual accesses or lets a window override special mode. Mask edges are probed with addresses just inside and just outside a window, and a window with only its instruction enable set is probed with a data access.

// File: rtl/amd_pkg.sv
package amd_pkg;
  parameter int ADDR_W = 32;
  parameter int ATTR_W = 8;
  parameter int N_MMU  = 1;
  parameter int N_RAM  = 2;
  parameter int N_ROM  = 2;
  parameter int N_ACR  = 2;
  localparam int N_WIN    = N_MMU + N_RAM + N_ROM + N_ACR;
  localparam int IDX_W    = $clog2(N_WIN + 1);
  localparam int SRC_NONE = N_WIN;
  localparam int MMU_IDX  = 0;

  typedef struct packed {
    logic              valid;
    logic              en_inst;
    logic              en_data;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
    logic [ATTR_W-1:0] attr;
  } win_cfg_t;
endpackage

// File: rtl/amd_win_regs.sv
module amd_win_regs
  import amd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  win_cfg_t          cfg_win_i,
  output win_cfg_t          win_o [N_WIN],
  output logic [ATTR_W-1:0] dflt_attr_o
);
  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        win_o[g] <= '0;
      else if (cfg_we_i && cfg_idx_i == IDX_W'(g))
        win_o[g] <= cfg_win_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      dflt_attr_o <= '0;
    else if (cfg_we_i && cfg_idx_i == IDX_W'(SRC_NONE))
      dflt_attr_o <= cfg_win_i.attr;
  end
endmodule

// File: rtl/amd_win_match.sv
module amd_win_match
  import amd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  win_cfg_t          win_i [N_WIN],
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_data_i,
  input  logic              super_i,
  input  logic              mmu_present_i,
  output logic [N_WIN-1:0]  hit_o
);
  for (genvar g = 0; g < N_WIN; g++) begin : g_cmp
    logic addr_eq, kind_ok, qual_ok;
    assign addr_eq = ((addr_i ^ win_i[g].base) & win_i[g].mask) == '0;
    assign kind_ok = is_data_i ? win_i[g].en_data : win_i[g].en_inst;
    if (g == MMU_IDX) begin : g_mmu
      assign qual_ok = is_data_i && super_i && mmu_present_i;
    end else begin : g_std
      assign qual_ok = 1'b1;
    end
    assign hit_o[g] = win_i[g].valid && addr_eq && kind_ok && qual_ok;
  end

  // MMU control window only for supervisor data
  assert_mmu_win_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o[MMU_IDX] |-> (is_data_i && super_i && mmu_present_i));
endmodule

// File: rtl/amd_prio_sel.sv
module amd_prio_sel
  import amd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_WIN-1:0]  hit_i,
  input  win_cfg_t          win_i [N_WIN],
  input  logic [ATTR_W-1:0] dflt_attr_i,
  input  logic              special_i,
  input  logic              mmu_on_i,
  output logic              virt_o,
  output logic [IDX_W-1:0]  src_o,
  output logic [ATTR_W-1:0] attr_o
);
  logic [N_WIN-1:0]  grant;
  logic [IDX_W-1:0]  win_idx;
  logic [ATTR_W-1:0] win_attr;

  always_comb begin
    grant    = '0;
    win_idx  = IDX_W'(SRC_NONE);
    win_attr = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        win_idx  = IDX_W'(i);
        win_attr = win_i[i].attr;
      end
    end
  end

  always_comb begin
    if (special_i) begin
      virt_o = 1'b0;
      src_o  = IDX_W'(SRC_NONE);
      attr_o = dflt_attr_i;
    end else if (|hit_i) begin
      virt_o = 1'b0;
      src_o  = win_idx;
      attr_o = win_attr;
    end else if (mmu_on_i) begin
      virt_o = 1'b1;
      src_o  = IDX_W'(SRC_NONE);
      attr_o = '0;
    end else begin
      virt_o = 1'b0;
      src_o  = IDX_W'(SRC_NONE);
      attr_o = dflt_attr_i;
    end
  end

  assert_grant_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((|hit_i) == (|grant)));
endmodule

// File: rtl/addr_mode_decoder.sv
module addr_mode_decoder
  import amd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_en_inst_i,
  input  logic              cfg_en_data_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_mask_i,
  input  logic [ATTR_W-1:0] cfg_attr_i,
  input  logic              mmu_present_i,
  input  logic              mmu_enable_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_data_i,
  input  logic              super_i,
  input  logic              special_i,
  output logic              valid_o,
  output logic              virt_o,
  output logic [IDX_W-1:0]  src_o,
  output logic [ATTR_W-1:0] attr_o
);
  win_cfg_t          cfg_win;
  win_cfg_t          win [N_WIN];
  logic [ATTR_W-1:0] dflt_attr;
  logic [N_WIN-1:0]  hit;
  logic              mmu_on;
  logic              nxt_virt;
  logic [IDX_W-1:0]  nxt_src;
  logic [ATTR_W-1:0] nxt_attr;

  assign cfg_win = '{valid: cfg_valid_i, en_inst: cfg_en_inst_i, en_data: cfg_en_data_i,
                     base: cfg_base_i, mask: cfg_mask_i, attr: cfg_attr_i};
  assign mmu_on  = mmu_present_i && mmu_enable_i;

  amd_win_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_win_i   (cfg_win),
    .win_o       (win),
    .dflt_attr_o (dflt_attr)
  );

  amd_win_match u_match (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .win_i         (win),
    .addr_i        (addr_i),
    .is_data_i     (is_data_i),
    .super_i       (super_i),
    .mmu_present_i (mmu_present_i),
    .hit_o         (hit)
  );

  amd_prio_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .win_i       (win),
    .dflt_attr_i (dflt_attr),
    .special_i   (special_i),
    .mmu_on_i    (mmu_on),
    .virt_o      (nxt_virt),
    .src_o       (nxt_src),
    .attr_o      (nxt_attr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      virt_o  <= 1'b0;
      src_o   <= IDX_W'(SRC_NONE);
      attr_o  <= '0;
    end else begin
      valid_o <= req_valid_i;
      virt_o  <= nxt_virt;
      src_o   <= nxt_src;
      attr_o  <= nxt_attr;
    end
  end

  assert_special_phys_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    special_i |-> (!nxt_virt && nxt_src == IDX_W'(SRC_NONE)));
  assert_mmu_off_phys_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mmu_on |-> !nxt_virt);
  assert_virt_nohit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_virt |-> (hit == '0 && nxt_attr == '0));
  assert_virt_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    virt_o |-> (src_o == IDX_W'(SRC_NONE) && attr_o == '0));
endmodule

// File: tb/sim_addr_mode_decoder.sv
module sim_addr_mode_decoder;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        cfg_we_i = 0;
  logic [2:0]  cfg_idx_i = 0;
  logic        cfg_valid_i = 0, cfg_en_inst_i = 0, cfg_en_data_i = 0;
  logic [31:0] cfg_base_i = 0, cfg_mask_i = 0;
  logic [7:0]  cfg_attr_i = 0;
  logic        mmu_present_i = 1, mmu_enable_i = 1;
  logic        req_valid_i = 0;
  logic [31:0] addr_i = 0;
  logic        is_data_i = 0, super_i = 0, special_i = 0;
  logic        valid_o, virt_o;
  logic [2:0]  src_o;
  logic [7:0]  attr_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  addr_mode_decoder u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit v, input bit ei, input bit ed,
                    input logic [31:0] b, input logic [31:0] m, input logic [7:0] a);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_idx_i = 3'(idx); cfg_valid_i = v; cfg_en_inst_i = ei;
    cfg_en_data_i = ed; cfg_base_i = b; cfg_mask_i = m; cfg_attr_i = a;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic acc(input logic [31:0] a, input bit d, input bit s, input bit sp);
    @(negedge clk_i);
    req_valid_i = 1; addr_i = a; is_data_i = d; super_i = s; special_i = sp;
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_out(input string req, input bit v, input int src, input logic [7:0] at);
    chk({req, " valid"}, 32'(valid_o), 32'(1'b1));
    chk({req, " virt"}, 32'(virt_o), 32'(v));
    chk({req, " src"}, 32'(src_o), 32'(src));
    chk({req, " attr"}, 32'(attr_o), 32'(at));
  endtask

  task automatic t_reset;
    chk("R1 valid", 32'(valid_o), 0);
    chk("R1 virt", 32'(virt_o), 0);
    chk("R1 src", 32'(src_o), 7);
    chk("R1 attr", 32'(attr_o), 0);
    acc(32'h1234_0000, 1, 1, 0);
    expect_out("R1 windows invalid", 1, 7, 8'h00);
  endtask

  task automatic t_default_and_off;
    wr(7, 0, 0, 0, 0, 0, 8'h5A);
    mmu_enable_i = 0;
    acc(32'h4000_0000, 1, 0, 0);
    expect_out("R3 disabled", 0, 7, 8'h5A);
    mmu_enable_i = 1; mmu_present_i = 0;
    acc(32'h4000_0000, 0, 0, 0);
    expect_out("R3 absent", 0, 7, 8'h5A);
    mmu_present_i = 1;
    acc(32'h4000_0000, 0, 0, 0);
    expect_out("R7 miss virtual R10", 1, 7, 8'h00);
  endtask

  task automatic t_match;
    wr(1, 1, 1, 1, 32'h2000_0000, 32'hFFF0_0000, 8'h11);
    acc(32'h200F_FFFC, 1, 0, 0);
    expect_out("R6 R8 inside", 0, 1, 8'h11);
    acc(32'h2010_0000, 1, 0, 0);
    expect_out("R8 outside", 1, 7, 8'h00);
  endtask

  task automatic t_priority;
    wr(3, 1, 1, 1, 32'h2000_0000, 32'hFF00_0000, 8'h33);
    acc(32'h2000_0100, 0, 0, 0);
    expect_out("R4 ram over rom", 0, 1, 8'h11);
    wr(2, 1, 1, 1, 32'h2000_0000, 32'hFFFF_0000, 8'h22);
    acc(32'h2000_0100, 0, 0, 0);
    expect_out("R4 ram0 over ram1", 0, 1, 8'h11);
    wr(1, 0, 1, 1, 32'h2000_0000, 32'hFFF0_0000, 8'h11);
    acc(32'h2000_0100, 0, 0, 0);
    expect_out("R4 ram1 after ram0 off", 0, 2, 8'h22);
    acc(32'h2050_0000, 0, 0, 0);
    expect_out("R4 rom only", 0, 3, 8'h33);
    wr(5, 1, 1, 1, 32'h7000_0000, 32'hF000_0000, 8'h55);
    wr(6, 1, 1, 1, 32'h7000_0000, 32'hFF00_0000, 8'h66);
    acc(32'h7000_0040, 1, 0, 0);
    expect_out("R4 acr0 over acr1", 0, 5, 8'h55);
    wr(4, 1, 1, 1, 32'h7000_0000, 32'hFFFF_F000, 8'h44);
    acc(32'h7000_0040, 1, 0, 0);
    expect_out("R4 rom over acr", 0, 4, 8'h44);
  endtask

  task automatic t_kind;
    wr(6, 1, 1, 0, 32'h9000_0000, 32'hF000_0000, 8'h69);
    acc(32'h9000_0000, 1, 1, 0);
    expect_out("R8 data blocked", 1, 7, 8'h00);
    acc(32'h9000_0000, 0, 1, 0);
    expect_out("R8 inst allowed", 0, 6, 8'h69);
  endtask

  task automatic t_mmu_win;
    wr(0, 1, 1, 1, 32'h2000_0000, 32'hFFFF_FF00, 8'h77);
    acc(32'h2000_0010, 1, 1, 0);
    expect_out("R5 R4 super data", 0, 0, 8'h77);
    acc(32'h2000_0010, 1, 0, 0);
    expect_out("R5 user data", 0, 2, 8'h22);
    acc(32'h2000_0010, 0, 1, 0);
    expect_out("R5 inst", 0, 2, 8'h22);
    mmu_present_i = 0;
    acc(32'h2000_0010, 1, 1, 0);
    expect_out("R5 absent", 0, 2, 8'h22);
    mmu_present_i = 1;
  endtask

  task automatic t_special;
    acc(32'h2000_0010, 1, 1, 1);
    expect_out("R2 hit ignored", 0, 7, 8'h5A);
    acc(32'hC000_0000, 1, 1, 1);
    expect_out("R2 miss", 0, 7, 8'h5A);
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    req_valid_i = 1; addr_i = 32'hC000_0000; special_i = 0; is_data_i = 1;
    #1;
    chk("R9 before edge virt", 32'(virt_o), 0);
    @(posedge clk_i); #1;
    chk("R9 after edge virt", 32'(virt_o), 1);
    @(negedge clk_i);
    req_valid_i = 0;
    @(posedge clk_i); #1;
    chk("R9 valid drop", 32'(valid_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset_pre: begin
      chk("R1 in reset src", 32'(src_o), 7);
    end
    @(negedge clk_i);
    rst_ni = 1;
    #1;
    t_reset();
    t_default_and_off();
    t_match();
    t_priority();
    t_kind();
    t_mmu_win();
    t_special();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule